// File: doc/BRIEF.md
# Servo Command Decoder and Demultiplexer

This block sits between a byte-pair assembler and a bank of servo pulse generators. Each accepted 16-bit command word holds two fields: a channel number and a target angle. The block turns the angle into a high-time count in clock cycles and places that count on an output data bus. The bus is shared by every channel. Alongside it, the block raises the one write strobe that belongs to the addressed channel. The count spans 1 ms to 2 ms at a 200 MHz clock.

A reserved command word, set by a parameter, does not address any channel. Instead it raises a single-cycle commit pulse that goes to all channels at the same moment. The pulse generators can then take their newly written values together, so every servo output changes in the same period. Results appear a fixed two cycles after the command is accepted, and the data and its strobe always arrive together.

Top module: `servo_cmd_demux`

## Requirements
- R1: The channel number is taken from bits [15:8] of the command word and the angle from bits [7:0].
- R2: For a written channel, the duty count is angle × 800 + 200000. Angles 200, 250 and 125 give 360000, 400000 and 300000.
- R3: An angle above 250 is treated as 250, which gives a count of 400000.
- R4: Channel number n, for n from 1 to 32, raises only wr_strobe bit n−1, for one cycle.
- R5: Every result (data, strobe, commit pulse) appears exactly two clock edges after the edge that accepted the command. The data and its strobe appear in the same cycle.
- R6: A command word equal to the MARKER parameter (default 16'hFFFF) raises update_pulse for one cycle and raises no write strobe.
- R7: A non-marker word with channel number 0 or above 32 raises no strobe and no update_pulse, and leaves duty_data unchanged.
- R8: While rst_n is low, wr_strobe and update_pulse are 0 and duty_data is 0. The same values hold on the first cycles after release.
- R9: duty_data keeps the last written count until the next channel write. Cycles with cmd_valid low produce no strobe and no commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid this cycle |
| cmd_word | input | 16 | Command word: channel number [15:8], angle [7:0] |
| duty_data | output | 20 | Duty count shared by all channels |
| wr_strobe | output | 32 | One-hot write strobe; bit n−1 addresses channel n |
| update_pulse | output | 1 | Commit pulse to all channels |

## Verification
The block has three results: the duty count, the strobe and the commit pulse. Each is due on the second rising edge after the edge that samples cmd_valid high. The bench drives inputs on falling edges and keeps a two-entry delay line of expected results. Every falling edge, it compares the oldest entry against the ports, so any change to the latency or any misalignment between data and strobe shows up as a mismatch. Directed sends also read the outputs one falling edge after their valid cycle ends, which is exactly that two-edge point. At that point they compare against hard-coded counts for the named angles and channels.

// File: rtl/servo_cmd_demux.sv
module servo_cmd_demux #(
  parameter int CHANNELS  = 32,
  parameter int ID_W      = 8,
  parameter int ANG_W     = 8,
  parameter int DUTY_W    = 20,
  parameter int ANGLE_MAX = 250,
  parameter int STEP      = 800,
  parameter int BASE      = 200000,
  parameter logic [ID_W+ANG_W-1:0] MARKER = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [ID_W+ANG_W-1:0]    cmd_word,
  output logic [DUTY_W-1:0]        duty_data,
  output logic [CHANNELS-1:0]      wr_strobe,
  output logic                     update_pulse
);
  localparam int IDX_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  logic [ANG_W-1:0] ang_in;
  logic [ID_W-1:0]  id_in;
  logic             is_marker;
  logic             id_ok;
  logic [ANG_W-1:0] ang_clamped;

  assign ang_in      = cmd_word[ANG_W-1:0];
  assign id_in       = cmd_word[ID_W+ANG_W-1:ANG_W];
  assign is_marker   = (cmd_word == MARKER);
  assign id_ok       = (id_in != '0) && (int'(id_in) <= CHANNELS);
  assign ang_clamped = (int'(ang_in) > ANGLE_MAX) ? ANG_W'(ANGLE_MAX) : ang_in;

  logic             s1_wr;
  logic             s1_mark;
  logic [IDX_W-1:0] s1_idx;
  logic [ANG_W-1:0] s1_ang;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_wr   <= 1'b0;
      s1_mark <= 1'b0;
      s1_idx  <= '0;
      s1_ang  <= '0;
    end else begin
      s1_wr   <= cmd_valid && !is_marker && id_ok;
      s1_mark <= cmd_valid && is_marker;
      s1_idx  <= IDX_W'(id_in - ID_W'(1));
      s1_ang  <= ang_clamped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_data    <= '0;
      update_pulse <= 1'b0;
    end else begin
      update_pulse <= s1_mark;
      if (s1_wr)
        duty_data <= DUTY_W'(s1_ang) * DUTY_W'(STEP) + DUTY_W'(BASE);
    end
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rst_n) wr_strobe[i] <= 1'b0;
      else        wr_strobe[i] <= s1_wr && (s1_idx == IDX_W'(i));
    end
  end
endmodule

module servo_cmd_demux_chk #(
  parameter int CHANNELS  = 32,
  parameter int DUTY_W    = 20,
  parameter int ANGLE_MAX = 250,
  parameter int STEP      = 800,
  parameter int BASE      = 200000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [DUTY_W-1:0]   duty_data,
  input logic [CHANNELS-1:0] wr_strobe,
  input logic                update_pulse
);
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));
  p_marker_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> (wr_strobe == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe == '0) |-> $stable(duty_data));
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe != '0) |-> (int'(duty_data) >= BASE && int'(duty_data) <= BASE + ANGLE_MAX * STEP));
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_strobe != '0) || update_pulse) |-> $past(cmd_valid, 2));
endmodule

bind servo_cmd_demux servo_cmd_demux_chk #(
  .CHANNELS(CHANNELS), .DUTY_W(DUTY_W), .ANGLE_MAX(ANGLE_MAX), .STEP(STEP), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .duty_data(duty_data),
  .wr_strobe(wr_strobe), .update_pulse(update_pulse)
);

// File: tb/servo_cmd_demux_tb.sv
module servo_cmd_demux_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MARK = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [19:0] duty_data;
  logic [31:0] wr_strobe;
  logic        update_pulse;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  servo_cmd_demux u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .duty_data(duty_data), .wr_strobe(wr_strobe), .update_pulse(update_pulse)
  );

  // reference: two-deep delay line of expected results
  logic [31:0] m_stb [2];
  logic        m_upd [2];
  int          m_dat [2];
  int          hold_dat = 0;

  always @(posedge clk) begin
    logic [31:0] ns;
    logic        nu;
    int          nd;
    int          id;
    int          ang;
    ns = '0; nu = 1'b0; nd = 0;
    id = int'(cmd_word[15:8]);
    ang = int'(cmd_word[7:0]);
    if (ang > 250) ang = 250;
    if (rst_n && cmd_valid) begin
      if (cmd_word == MARK) nu = 1'b1;
      else if (id >= 1 && id <= 32) begin
        ns = 32'h1 << (id - 1);
        nd = ang * 800 + 200000;
      end
    end
    if (!rst_n) begin
      m_stb[0] = '0; m_stb[1] = '0; m_upd[0] = 0; m_upd[1] = 0;
      m_dat[0] = 0; m_dat[1] = 0; hold_dat = 0;
    end else begin
      m_stb[1] = m_stb[0]; m_upd[1] = m_upd[0];
      if (m_stb[0] != '0) hold_dat = m_dat[0];
      m_dat[1] = hold_dat;
      m_stb[0] = ns; m_upd[0] = nu; m_dat[0] = nd;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R5 alignment, R9 hold)
  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check("R5/R4 strobe", int'(wr_strobe), int'(m_stb[1]));
      check("R5/R6 update", int'(update_pulse), int'(m_upd[1]));
      check("R9/R2 data", int'(duty_data), m_dat[1]);
    end
  end

  task automatic send(logic [15:0] w);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cmd_valid = 1'b1; cmd_word = 16'h01C8;
    repeat (4) @(negedge clk);
    check("R8 reset strobe", int'(wr_strobe), 0);
    check("R8 reset update", int'(update_pulse), 0);
    check("R8 reset data", int'(duty_data), 0);
    cmd_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", int'(wr_strobe), 0);
    model_on = 1;

    send(16'h01C8);
    check("R2 angle 200", int'(duty_data), 360000);
    check("R1 R4 id 1", int'(wr_strobe), 32'h1);
    send(16'h02FA);
    check("R2 angle 250", int'(duty_data), 400000);
    check("R4 id 2", int'(wr_strobe), 32'h2);
    send(16'h047D);
    check("R2 angle 125", int'(duty_data), 300000);
    check("R4 id 4", int'(wr_strobe), 32'h8);
    send(16'h2000);
    check("R4 id 32", int'(wr_strobe), 32'h8000_0000);
    check("R2 angle 0", int'(duty_data), 200000);
    send(16'h05FF);
    check("R3 clamp 255", int'(duty_data), 400000);
    send(16'h0064);
    check("R7 id 0 strobe", int'(wr_strobe), 0);
    check("R7 id 0 data", int'(duty_data), 400000);
    send(16'h2164);
    check("R7 id 33 strobe", int'(wr_strobe), 0);
    check("R7 id 33 data", int'(duty_data), 400000);
    send(MARK);
    check("R6 marker pulse", int'(update_pulse), 1);
    check("R6 marker no write", int'(wr_strobe), 0);
    check("R6 marker data", int'(duty_data), 400000);
    @(negedge clk);
    check("R6 pulse one cycle", int'(update_pulse), 0);
    check("R9 idle hold", int'(duty_data), 400000);

    // back-to-back words
    @(negedge clk);
    for (int i = 1; i <= 32; i++) begin
      cmd_valid = 1'b1; cmd_word = {8'(i), 8'(i * 7)};
      @(negedge clk);
    end
    cmd_word = MARK; @(negedge clk);
    cmd_valid = 1'b0; repeat (3) @(negedge clk);

    for (int i = 0; i < 2000; i++) begin
      cmd_valid = ($urandom_range(0, 3) != 0);
      cmd_word = ($urandom_range(0, 15) == 0) ? MARK : 16'($urandom_range(0, 16'h2AFF));
      @(negedge clk);
    end
    cmd_valid = 1'b0; repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule